// File: doc/BRIEF.md
# Selectable Ratio Clock Divider

The block derives a single divided clock from a reference clock. A 4-bit ratio code picks one of sixteen division ratios. The set is irregular. Besides integer ratios from 1 to 192, it holds the half-integer ratio 1.5. The divided clock drives the status pin multiplexer, and both status pins share it.

Internally, the block tracks its position in the output period in units of reference half-periods. A flop on the rising edge and a flop on the falling edge of the reference each toggle when an output edge falls in their half. The XOR of the two flops is the output. This lets ratios 1.5 and 3 place edges on falling reference edges.

A new code is taken only where an output period begins. A change of ratio while running therefore never shortens a high or low phase.

Top module: `clkdiv_sel`

## Requirements
- R1: Code c on `ratio_sel_i` gives an output period of ratio(c) reference periods, measured between consecutive rising edges of `clk_o`. Codes 0 to 15 map to ratios 1, 1.5, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192 in that order.
- R2: While `rst_ni` is low, `clk_o` is low. The first output period after reset release uses ratio 192 (code 15), whatever code is applied.
- R3: The first rising edge of `clk_o` after reset release occurs at the first rising edge of `clk_i`.
- R4: With code 0, the output period equals the reference period, `clk_o` changes at every reference edge, and the high phase is one reference half-period.
- R5: With code 1, the output period is three reference half-periods: high for one half-period and low for two.
- R6: With codes 2 to 15, the high phase and the low phase each last exactly half the output period. For ratio 3, this means a falling reference edge ends the high phase.
- R7: A code is sampled on the rising `clk_i` edge that coincides with, or directly follows, a rising edge of `clk_o`. That code governs the period starting at that rising edge, and the period already in progress keeps its own high and low lengths.
- R8: Changes of `ratio_sel_i` at any other time have no effect on `clk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | 4 | Ratio code, synchronous to `clk_i` |
| clk_o | output | 1 | Divided clock |

## Verification
The bench times every output period and high phase against the reference period for all sixteen codes. A divider that mishandled the 1.5 ratio, or placed the ratio-3 fall on a rising edge, would show a wrong period or a 33/67 duty instead of 50/50.

Codes are switched during the low phase of a period, including jumps between the extreme ratios. A design that applied a code at once would produce a truncated period where the bench expects the old or the new length.

A burst of foreign codes is applied in mid-period and then withdrawn. A design that latched codes outside the period boundary would stretch or shrink that period.

The reset case applies code 0 during reset. A divider that ignored the fixed first ratio would emit a reference-rate period first.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Output period in reference half-periods for a code: even -> 2^(c/2+1), odd -> 3*2^((c-1)/2)
  function automatic int half_len(int code);
    if (code % 2 == 1) return 3 << ((code - 1) / 2);
    return 1 << (code / 2 + 1);
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int W      = 9
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [W-1:0]      half_o
);
  localparam int NCODE = 2 ** CODE_W;

  logic [W-1:0] lut [NCODE];

  for (genvar c = 0; c < NCODE; c++) begin : g_lut
    assign lut[c] = W'(half_len(c));
  end

  assign half_o = lut[code_i];
endmodule

// File: rtl/clkdiv_sched.sv
module clkdiv_sched #(
  parameter int W        = 9,
  parameter int RST_HALF = 384
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] half_i,
  output logic         lvl_pos_o,
  output logic         tog_neg_o,
  output logic [W-1:0] half_o
);
  logic [W-1:0] ph_q, half_q;
  logic [W-1:0] sum, ph_nx, half_nx, hi_nx, nidx;
  logic         first_q, wrap, pos_tg, neg_tg, p_q, nt_q;

  // ph_q: half-period index at this rising edge; steps by two per reference cycle
  always_comb begin
    sum     = ph_q + W'(2);
    wrap    = sum >= half_q;
    ph_nx   = wrap ? sum - half_q : sum;
    half_nx = (wrap && !first_q) ? half_i : half_q;
    hi_nx   = half_nx >> 1;
    nidx    = ph_nx + W'(1);
    if (nidx == half_nx) nidx = '0;
    pos_tg  = (ph_nx == '0) || (ph_nx == hi_nx);
    neg_tg  = (nidx == '0) || (nidx == hi_nx);
  end

  // Reset places the index one step before a wrap, so the first edge rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= W'(RST_HALF - 2);
      half_q  <= W'(RST_HALF);
      first_q <= 1'b1;
      p_q     <= 1'b0;
      nt_q    <= 1'b0;
    end else begin
      ph_q    <= ph_nx;
      half_q  <= half_nx;
      first_q <= 1'b0;
      p_q     <= p_q ^ pos_tg;
      nt_q    <= neg_tg;
    end
  end

  assign lvl_pos_o = p_q;
  assign tog_neg_o = nt_q;
  assign half_o    = half_q;

  p_phase_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < half_q);

  p_half_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q >= W'(2) && ($onehot(half_q) || (half_q % 3 == 0 && $onehot(half_q / 3))));

  p_code_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q + W'(2) < half_q) |=> $stable(half_q));
endmodule

// File: rtl/clkdiv_negstage.sv
module clkdiv_negstage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic lvl_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= 1'b0;
    else         lvl_o <= lvl_o ^ tog_i;
  end
endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
  import clkdiv_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 2 ** CODE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_sel_i,
  output logic              clk_o
);
  localparam int MAX_HALF = half_len(2 ** CODE_W - 1);
  localparam int W        = $clog2(MAX_HALF + 2);
  localparam int RST_HALF = half_len(RST_CODE);

  logic [W-1:0] half_dec, half_q;
  logic         lvl_pos, tog_neg, lvl_neg;

  clkdiv_decode #(.CODE_W(CODE_W), .W(W)) i_decode (
    .code_i (ratio_sel_i),
    .half_o (half_dec)
  );

  clkdiv_sched #(.W(W), .RST_HALF(RST_HALF)) i_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .half_i    (half_dec),
    .lvl_pos_o (lvl_pos),
    .tog_neg_o (tog_neg),
    .half_o    (half_q)
  );

  clkdiv_negstage i_negstage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tog_i  (tog_neg),
    .lvl_o  (lvl_neg)
  );

  // Only one of the two levels changes at any reference edge
  assign clk_o = lvl_pos ^ lvl_neg;

  // Ratio 1 settled: output seen at each rising reference edge never changes
  p_ratio1_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q == W'(2) && $past(half_q) == W'(2)) |-> $stable(clk_o));
endmodule

// File: tb/test_clkdiv_sel.sv
`timescale 1ns/1ps
module test_clkdiv_sel;
  localparam int HALF_TAB [16] = '{2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ratio_sel_i = 4'd0;
  logic       clk_o;

  always #2 clk_i = ~clk_i;  // 250 MHz, half-period 2 ns

  clkdiv_sel i_clkdiv_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_sel_i (ratio_sel_i),
    .clk_o       (clk_o)
  );

  int    n_vec = 0, n_bad = 0;
  bit    reported = 0;
  int    q_half [$];
  string q_tp [$];
  string q_th [$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Monitor: each completed period is compared with the next expected entry
  longint t_rise = 0, t_fall = 0;
  bit     have_rise = 0;

  always @(negedge clk_o) t_fall = $time;

  always @(posedge clk_o) begin
    int h;
    string tp, th;
    if (have_rise && q_half.size() > 0) begin
      h  = q_half.pop_front();
      tp = q_tp.pop_front();
      th = q_th.pop_front();
      check(($time - t_rise) == longint'(h * 2), tp, "period ns", $time - t_rise, h * 2);
      check((t_fall - t_rise) == longint'((h / 2) * 2), th, "high ns", t_fall - t_rise, (h / 2) * 2);
    end
    t_rise    = $time;
    have_rise = 1;
  end

  function automatic string tag_period(int c);
    if (c == 0) return "R4";
    if (c == 1) return "R5";
    return "R1";
  endfunction

  function automatic string tag_high(int c);
    if (c == 0) return "R4";
    if (c == 1) return "R5";
    return "R6";
  endfunction

  // Driver: new code applied during the low phase; pushes the periods it expects
  task automatic run_code(int c, int n);
    @(negedge clk_o);
    #1 ratio_sel_i = c[3:0];
    for (int k = 0; k < n; k++) begin
      q_half.push_back(HALF_TAB[c]);
      q_tp.push_back(k == 0 ? "R7" : tag_period(c));
      q_th.push_back(k == 0 ? "R7" : tag_high(c));
    end
    repeat (n) @(posedge clk_o);
  endtask

  // R8: foreign codes in mid-period, withdrawn before the next boundary
  task automatic run_perturb(int c);
    @(negedge clk_o);
    #1 ratio_sel_i = c[3:0];
    for (int k = 0; k < 3; k++) begin
      q_half.push_back(HALF_TAB[c]);
      q_tp.push_back("R8");
      q_th.push_back("R8");
    end
    @(posedge clk_o);
    @(posedge clk_o);
    #9  ratio_sel_i = 4'd0;
    #10 ratio_sel_i = 4'd5;
    #10 ratio_sel_i = 4'd15;
    #10 ratio_sel_i = c[3:0];
    @(posedge clk_o);
  endtask

  initial begin
    // First period after reset is fixed at ratio 192 while code 0 is applied
    q_half.push_back(384);
    q_tp.push_back("R2");
    q_th.push_back("R2");
    #11 check(clk_o == 1'b0, "R2", "clk_o in reset", clk_o, 0);
    #10 rst_ni = 1'b1;                        // t=21, clk low
    #0.5 check(clk_o == 1'b0, "R3", "clk_o before first edge", clk_o, 0);
    @(posedge clk_i);
    #1 check(clk_o == 1'b1, "R3", "clk_o after first edge", clk_o, 1);
    for (int c = 0; c < 16; c++) run_code(c, 3);
    run_code(0, 2);
    run_code(15, 2);
    run_code(1, 3);
    run_code(3, 2);
    run_code(2, 2);
    run_perturb(12);
    wait (q_half.size() == 0);
    #1 report();
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R1 watchdog expired with %0d periods pending", q_half.size());
    report();
  end
endmodule